// File: doc/BRIEF.md
# Single-Channel Sample Capture Engine

This block is the capture core of a one-bit logic analyser. When it leaves reset it announces itself with a ready byte. It then waits, armed, until the monitored line goes high. From then on it takes one sample on every sample-tick strobe and packs eight samples into a byte. It writes the bytes to consecutive locations of a 128-byte on-chip buffer. When the buffer is full, capture stops and a finish byte is sent.

After capture the block waits for single-byte commands on a byte receive interface. A transfer command streams the whole buffer out in address order. A re-initialise command clears the capture state, repeats the ready byte and arms the trigger again. Outgoing bytes use a valid/ready handshake toward an external serializer. Incoming bytes arrive as one-cycle valid strobes. The probed line passes through a two-flop synchroniser before it is used.

The state machine has six states:
- READY sends the ready byte 0x72.
- ARM waits for the synchronised probe to be high.
- CAPTURE takes the samples.
- FINISH sends the finish byte 0x66.
- IDLE decodes commands.
- XFER streams the buffer out.

The transitions are:
- READY→ARM on acceptance of the ready byte.
- ARM→CAPTURE on a high synchronised probe.
- CAPTURE→FINISH when the last buffer byte is written.
- FINISH→IDLE on acceptance of the finish byte.
- IDLE→XFER on 0x54.
- IDLE→READY on 0x52.
- XFER→IDLE on acceptance of the last buffer byte.

Top module: `cap_engine`

## Requirements
- R1: After reset the first byte offered on tx_data is 0x72. It is offered with tx_valid high, and the block makes no other transfer before it.
- R2: In the ARM state, sample ticks are ignored and received bytes are ignored (including 0x54), until the synchronised probe is high. No byte is offered while armed.
- R3: Each accepted tick shifts the synchronised probe bit into a byte. The first sample of a group of eight lands in bit 7 and the eighth lands in bit 0.
- R4: Every group of eight samples is written to the next buffer address, starting at address 0. After the 128th byte, capture stops and further ticks leave the buffer unchanged.
- R5: When capture ends, the byte 0x66 is offered once. After it is accepted, the block is idle and offers nothing.
- R6: In IDLE, the received byte 0x54 streams all 128 buffer bytes in address order, from address 0. The block then returns to IDLE, and the command can be repeated.
- R7: In IDLE, the received byte 0x52 clears the pointers and the bit counter, offers 0x72 again, and re-arms the trigger. The next capture starts at address 0 with a fresh byte.
- R8: In IDLE, any received byte other than 0x54 and 0x52 is ignored. No byte is offered and the state does not change.
- R9: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change. One byte moves per cycle in which both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_in | input | 1 | Monitored line (asynchronous) |
| sample_tick | input | 1 | One-clock sample strobe |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | rx_data valid for this cycle |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | Serializer accepts tx_data |

## Verification
The capture is driven with a sixteen-entry table of byte patterns, repeated over the 128 buffer bytes. The table holds all-zero, all-one, alternating, single-bit and nibble patterns, so a reversed packing order, a lost bit or a shifted bit-counter boundary each produce a mismatch. A second capture after re-initialisation uses the inverted table. This shows that the buffer is rewritten from address 0 and that no leftover bit count carries over. Ticks sent while armed and ticks sent after the buffer is full separate correct gating from counting at the wrong time. Stray and early commands, together with a stalled serializer, exercise the idle decoding and the hold behaviour of the handshake.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_READY  = 8'h72;
    localparam logic [BYTE_W-1:0] CODE_FINISH = 8'h66;
    localparam logic [BYTE_W-1:0] CMD_DUMP    = 8'h54;
    localparam logic [BYTE_W-1:0] CMD_REINIT  = 8'h52;

    typedef enum logic [2:0] {
        S_READY,
        S_ARM,
        S_CAPTURE,
        S_FINISH,
        S_IDLE,
        S_XFER
    } state_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/cap_packer.sv
module cap_packer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic         tick,
    input  logic         bit_in,
    output logic         word_valid,
    output logic [W-1:0] word_data
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;
    logic             take;

    assign take = enable && tick;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (take) begin
            shreg <= {shreg[W-2:0], bit_in};
            if (cnt == CNT_LAST) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign word_valid = take && (cnt == CNT_LAST);
    assign word_data  = {shreg[W-2:0], bit_in};
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cap_engine.sv
module cap_engine #(
    parameter int DEPTH       = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       probe_in,
    input  logic       sample_tick,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready
);
    import cap_pkg::*;

    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

    state_t state, state_nx;

    logic              probe_s;
    logic              word_valid;
    logic [BYTE_W-1:0] word_data;
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;
    logic [BYTE_W-1:0] buf_rdata;
    logic              tx_fire;
    logic              wr_en;
    logic              in_capture;
    logic              clr_capture;

    assign tx_fire     = tx_valid && tx_ready;
    assign in_capture  = (state == S_CAPTURE);
    assign clr_capture = (state == S_READY);
    assign wr_en       = word_valid;

    cap_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (probe_in),
        .d_out (probe_s)
    );

    cap_packer #(.W(BYTE_W)) i_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clr_capture),
        .enable     (in_capture),
        .tick       (sample_tick),
        .bit_in     (probe_s),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    cap_buffer #(.DEPTH(DEPTH), .W(BYTE_W)) i_buffer (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wptr),
        .wdata (word_data),
        .raddr (rptr),
        .rdata (buf_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_READY;
        end else begin
            state <= state_nx;
        end
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_READY:   if (tx_fire) state_nx = S_ARM;
            S_ARM:     if (probe_s) state_nx = S_CAPTURE;
            S_CAPTURE: if (word_valid && wptr == ADDR_LAST) state_nx = S_FINISH;
            S_FINISH:  if (tx_fire) state_nx = S_IDLE;
            S_IDLE: begin
                if (rx_valid && rx_data == CMD_DUMP) begin
                    state_nx = S_XFER;
                end else if (rx_valid && rx_data == CMD_REINIT) begin
                    state_nx = S_READY;
                end
            end
            S_XFER:    if (tx_fire && rptr == ADDR_LAST) state_nx = S_IDLE;
            default:   state_nx = S_READY;
        endcase
    end

    // Buffer pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (clr_capture) begin
                wptr <= '0;
            end else if (wr_en) begin
                wptr <= wptr + 1'b1;
            end
            if (state == S_IDLE) begin
                rptr <= '0;
            end else if (state == S_XFER && tx_fire) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    // Output logic
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        unique case (state)
            S_READY: begin
                tx_valid = 1'b1;
                tx_data  = CODE_READY;
            end
            S_FINISH: begin
                tx_valid = 1'b1;
                tx_data  = CODE_FINISH;
            end
            S_XFER: begin
                tx_valid = 1'b1;
                tx_data  = buf_rdata;
            end
            default: begin
                tx_valid = 1'b0;
                tx_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/cap_engine_chk.sv
module cap_engine_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input cap_pkg::state_t   state,
    input logic              probe_s,
    input logic              sample_tick,
    input logic [7:0]        rx_data,
    input logic              rx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wptr,
    input logic [ADDR_W-1:0] rptr
);
    import cap_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = '1;

    // R9: an offered byte is held while the serializer stalls
    a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R2: armed with a low probe, nothing moves on
    a_r2_stay_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARM && !probe_s) |=> (state == S_ARM));

    // R4: buffer writes happen only during capture
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == S_CAPTURE));

    // R5: leaving capture only after the last address was written
    a_r5_finish_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CAPTURE && $past(state) == S_CAPTURE && !wr_en) |=> (state == S_CAPTURE));

    // R5: writing the last address ends capture
    a_r5_full_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wptr == LAST) |=> (state == S_FINISH));

    // R6: last streamed byte returns to idle
    a_r6_xfer_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER && tx_valid && tx_ready && rptr == LAST) |=> (state == S_IDLE));

    // R8: stray command bytes leave idle untouched
    a_r8_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && (!rx_valid || (rx_data != CMD_DUMP && rx_data != CMD_REINIT)))
        |=> (state == S_IDLE));

    // R1: the ready byte is what READY offers
    a_r1_ready_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY) |-> (tx_valid && tx_data == CODE_READY));
endmodule

bind cap_engine cap_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .probe_s     (probe_s),
    .sample_tick (sample_tick),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .wr_en       (wr_en),
    .wptr        (wptr),
    .rptr        (rptr)
);

// File: tb/test_cap_engine.sv
`timescale 1ns/1ps
module test_cap_engine;
    localparam int NBYTES = 128;

    localparam logic [7:0] PAT [16] = '{
        8'h00, 8'hFF, 8'hAA, 8'h55, 8'h80, 8'h01, 8'h0F, 8'hF0,
        8'h3C, 8'hC3, 8'h96, 8'h69, 8'h40, 8'h02, 8'hE7, 8'h18
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       probe_in = 1'b0;
    logic       sample_tick = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cap_engine i_cap_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .probe_in    (probe_in),
        .sample_tick (sample_tick),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_byte(input int k, input bit inv);
        return PAT[k % 16] ^ (inv ? 8'hFF : 8'h00);
    endfunction

    task automatic tick_sample(input logic b);
        probe_in = b;
        repeat (3) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        rx_data  = c;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data  = 8'h00;
    endtask

    task automatic get_byte(output logic [7:0] b, input string req);
        int n = 0;
        while (!tx_valid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(tx_valid, req, 0, 1);
        b = tx_data;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic quiet(input int cyc, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (tx_valid) seen = 1'b1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic capture(input bit inv);
        probe_in = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < NBYTES; k++) begin
            for (int j = 7; j >= 0; j--) begin
                tick_sample(expect_byte(k, inv)[j]);
            end
        end
    endtask

    task automatic dump_and_compare(input bit inv, input string req);
        logic [7:0] b;
        send_cmd(8'h54);
        for (int k = 0; k < NBYTES; k++) begin
            get_byte(b, req);
            check(b == expect_byte(k, inv), req, b, expect_byte(k, inv));
        end
        quiet(6, "R6 idle after dump");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: ready byte first, held under a stall (R9)
        check(tx_valid && tx_data == 8'h72, "R1 ready byte", tx_data, 8'h72);
        repeat (4) @(negedge clk);
        check(tx_valid && tx_data == 8'h72, "R9 hold under stall", tx_data, 8'h72);
        get_byte(b, "R1 ready byte");
        check(b == 8'h72, "R1 ready byte", b, 8'h72);

        // R2: ticks and commands while armed are ignored
        probe_in = 1'b0;
        for (int i = 0; i < 10; i++) tick_sample(1'b0);
        send_cmd(8'h54);
        send_cmd(8'h52);
        quiet(20, "R2 armed stays silent");

        // R3/R4: capture the pattern table
        capture(1'b0);

        // R5: finish byte, stalled then accepted
        @(negedge clk);
        check(tx_valid && tx_data == 8'h66, "R5 finish byte", tx_data, 8'h66);
        repeat (5) @(negedge clk);
        check(tx_valid && tx_data == 8'h66, "R9 finish held", tx_data, 8'h66);
        get_byte(b, "R5 finish byte");
        check(b == 8'h66, "R5 finish byte", b, 8'h66);
        check(!tx_valid, "R5 idle after finish", tx_valid, 0);

        // R4: extra ticks after full change nothing
        for (int i = 0; i < 16; i++) tick_sample(i[0]);
        quiet(4, "R4 no output after full");

        // R8: stray byte ignored
        send_cmd(8'h41);
        send_cmd(8'h72);
        quiet(10, "R8 stray byte silent");

        // R3/R4/R6: dump, then dump again
        dump_and_compare(1'b0, "R3 R4 R6 first dump");
        dump_and_compare(1'b0, "R6 repeated dump");

        // R7: re-initialise and capture inverted table
        send_cmd(8'h52);
        get_byte(b, "R7 ready again");
        check(b == 8'h72, "R7 ready again", b, 8'h72);
        probe_in = 1'b0;
        quiet(8, "R7 re-armed silent");
        capture(1'b1);
        get_byte(b, "R7 second finish");
        check(b == 8'h66, "R7 second finish", b, 8'h66);
        dump_and_compare(1'b1, "R7 fresh capture");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule